// File: doc/BRIEF.md
# DMA Controller Host Register Port

This block is the 8-bit programming port of a four-channel DMA controller. A host selects one of sixteen locations with a 4-bit address and a read or write strobe. Through that port it loads each channel's 16-bit start address and transfer count, the per-channel mode bytes, the global command byte, the software request bits and the channel masks. It reads back status, the request and mask bits, the mode bytes and the last byte moved in a memory-to-memory operation.

The 16-bit values travel as two byte accesses. A byte pointer toggles on every access to those locations, and a dedicated command puts it back to the low byte. Mode bytes are read back in a fixed channel order that a small counter steps. Some locations carry no data. A write or read to them is a software command: clear the byte pointer, clear the mode-read counter, clear all masks, or a full master clear. The transfer engine is a separate block. It sees every register through output ports, and it feeds in terminal-count pulses, raw request lines and memory-to-memory data bytes. Programming is accepted only while the chip is selected and the system bus is not granted to the DMA.

Top module: `dma_hostif`

Address map: 0..7 are the channel registers. Bits 2:1 give the channel and bit 0 picks address (0) or count (1). The other locations are:
- 8: write command, read status.
- 9: write or read request.
- 10: write single mask, read command.
- 11: write mode, read mode.
- 12: write clears the byte pointer; read clears the mode-read counter and returns 0xFF.
- 13: write is master clear, read returns the temporary byte.
- 14: write clears all masks.
- 15: write or read all masks.

All other reads return 0xFF. When no read is accepted, `rdata` is 0x00.

## Requirements
- R1: Every accepted read or write at addresses 0..7 moves one byte of the selected 16-bit register, the low byte when the byte pointer is clear and the high byte when it is set, and then toggles the pointer. Reset clears the pointer, and so does a write to address 12.
- R2: A write to address 13 does the same as reset for these registers. It clears command, status flags, request bits, the temporary byte, the byte pointer and the mode-read counter, and it sets all four mask bits.
- R3: A mode write stores data bits 7:2 as the mode of the channel in bits 1:0. A mode read returns the stored 6 bits in 7:2, with bits 1:0 reading as ones.
- R4: Successive mode reads return channel 0, 1, 2, 3 and then wrap. A read of address 12 restarts the order at channel 0.
- R5: A request write sets (bit 2 = 1) or clears (bit 2 = 0) the request bit of the channel in bits 1:0. A request read returns the bits in 3:0 with ones in 7:4.
- R6: The mask bits are changed in three ways. A single-mask write sets or clears one bit, with the channel in bits 1:0 and the value in bit 2. A write to address 15 loads all four bits from bits 3:0. A write to address 14 clears all four. A mask read returns ones in 7:4.
- R7: The command write stores the full byte on `cmd_o`, and the command read (address 10) returns it.
- R8: A status read returns the request lines OR the request bits in 7:4, regardless of mask, and the terminal-count flags in 3:0. A `tc_set` pulse sets a flag. A status read clears the flags, but a pulse in the same cycle survives.
- R9: The temporary byte loads from `tmp_data` on `tmp_load` and reads back at address 13.
- R10: Nothing is read, written or commanded while `sel` is low or `hold_ack` is high. In that case `rdata` is 0x00.
- R11: Software commands ignore the data bus. A clear-pointer write with data 0xFF changes nothing but the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Chip select, active high |
| hold_ack | input | 1 | Bus granted to DMA; blocks programming |
| rd | input | 1 | Read strobe, one access per cycle |
| wr | input | 1 | Write strobe, one access per cycle |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during an accepted read |
| dreq_in | input | 4 | Raw channel request lines, for status |
| tc_set | input | 4 | Terminal-count pulses from the engine |
| tmp_load | input | 1 | Load the temporary byte |
| tmp_data | input | 8 | Byte moved in memory-to-memory mode |
| cmd_o | output | 8 | Command byte |
| mode_o | output | 24 | Per-channel 6-bit modes, channel 0 in bits 5:0 |
| req_o | output | 4 | Software request bits |
| mask_o | output | 4 | Mask bits |
| ch_addr_o | output | 64 | Per-channel 16-bit start address, channel 0 lowest |
| ch_cnt_o | output | 64 | Per-channel 16-bit count, channel 0 lowest |

## Verification
The hardest states to reach are those where hidden sequencing state disagrees with what the host expects. One example is a byte pointer left on the high byte by an odd number of accesses when a master clear or clear-pointer command arrives. Another is a mode-read counter left mid-sequence when the restart read comes. The stimulus leaves the pointer on the high byte on purpose before each clearing command, then writes a single byte and checks which half of the 16-bit output it reached. It also interrupts a mode readback after two reads. The terminal-count clear-on-read race is reached by pulsing `tc_set` in the same cycle as a status read.

// File: rtl/dma_hostif.sv
module dma_hostif (
  input  logic        clk,
  input  logic        rst,
  input  logic        sel,
  input  logic        hold_ack,
  input  logic        rd,
  input  logic        wr,
  input  logic [3:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [3:0]  dreq_in,
  input  logic [3:0]  tc_set,
  input  logic        tmp_load,
  input  logic [7:0]  tmp_data,
  output logic [7:0]  cmd_o,
  output logic [23:0] mode_o,
  output logic [3:0]  req_o,
  output logic [3:0]  mask_o,
  output logic [63:0] ch_addr_o,
  output logic [63:0] ch_cnt_o
);
  localparam logic [3:0] A_CMD = 4'd8, A_REQ = 4'd9, A_SMASK = 4'd10, A_MODE = 4'd11,
                         A_CLRPTR = 4'd12, A_MCLR = 4'd13, A_CLRMSK = 4'd14, A_AMASK = 4'd15;

  logic [7:0]  cmd_r, tmp_r;
  logic [3:0]  req_r, mask_r, tc_r;
  logic        bptr;
  logic [1:0]  mctr;
  logic [5:0]  mode_r [4];
  logic [15:0] adr_r  [4];
  logic [15:0] cnt_r  [4];

  wire acc      = sel && !hold_ack;
  wire wr_ok    = acc && wr;
  wire rd_ok    = acc && rd && !wr;
  wire chan_acc = !addr[3] && (wr_ok || rd_ok);
  wire mclr     = wr_ok && addr == A_MCLR;
  wire [1:0] ch = addr[2:1];
  wire [1:0] dch = wdata[1:0];

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      cmd_r  <= '0;
      tmp_r  <= '0;
      req_r  <= '0;
      tc_r   <= '0;
      mask_r <= 4'hF;
      bptr   <= 1'b0;
      mctr   <= '0;
    end else begin
      if (tmp_load) tmp_r <= tmp_data;
      tc_r <= (tc_r & ~{4{rd_ok && addr == A_CMD}}) | tc_set;
      if (wr_ok && addr == A_CLRPTR) bptr <= 1'b0;
      else if (chan_acc) bptr <= ~bptr;
      if (rd_ok && addr == A_CLRPTR) mctr <= '0;
      else if (rd_ok && addr == A_MODE) mctr <= mctr + 2'd1;
      if (wr_ok) begin
        case (addr)
          A_CMD:    cmd_r       <= wdata;
          A_REQ:    req_r[dch]  <= wdata[2];
          A_SMASK:  mask_r[dch] <= wdata[2];
          A_CLRMSK: mask_r      <= '0;
          A_AMASK:  mask_r      <= wdata[3:0];
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        mode_r[i] <= '0;
        adr_r[i]  <= '0;
        cnt_r[i]  <= '0;
      end
    end else if (wr_ok) begin
      if (addr == A_MODE) mode_r[dch] <= wdata[7:2];
      if (!addr[3]) begin
        if (!addr[0]) begin
          if (bptr) adr_r[ch][15:8] <= wdata; else adr_r[ch][7:0] <= wdata;
        end else begin
          if (bptr) cnt_r[ch][15:8] <= wdata; else cnt_r[ch][7:0] <= wdata;
        end
      end
    end
  end

  logic [15:0] word_sel;
  assign word_sel = addr[0] ? cnt_r[ch] : adr_r[ch];

  always_comb begin
    rdata = 8'h00;
    if (rd_ok) begin
      case (addr)
        A_CMD:    rdata = {dreq_in | req_r, tc_r};
        A_REQ:    rdata = {4'hF, req_r};
        A_SMASK:  rdata = cmd_r;
        A_MODE:   rdata = {mode_r[mctr], 2'b11};
        A_MCLR:   rdata = tmp_r;
        A_AMASK:  rdata = {4'hF, mask_r};
        default:  rdata = addr[3] ? 8'hFF : (bptr ? word_sel[15:8] : word_sel[7:0]);
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      mode_o[i*6 +: 6]     = mode_r[i];
      ch_addr_o[i*16 +: 16] = adr_r[i];
      ch_cnt_o[i*16 +: 16]  = cnt_r[i];
    end
  end

  assign cmd_o  = cmd_r;
  assign req_o  = req_r;
  assign mask_o = mask_r;
endmodule

// File: rtl/dma_hostif_chk.sv
module dma_hostif_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel,
  input logic       hold_ack,
  input logic       rd,
  input logic       wr,
  input logic [3:0] addr,
  input logic [7:0] rdata,
  input logic [7:0] cmd_o,
  input logic [3:0] mask_o,
  input logic       bptr,
  input logic [1:0] mctr
);
  wire acc_w = sel && !hold_ack && wr;
  wire acc_r = sel && !hold_ack && rd && !wr;

  assert_mclr_R2: assert property (@(posedge clk) disable iff (rst)
    acc_w && addr == 4'd13 |=> mask_o == 4'hF && cmd_o == 8'h00 && !bptr && mctr == 2'd0);

  assert_ptr_toggle_R1: assert property (@(posedge clk) disable iff (rst)
    (acc_w || acc_r) && !addr[3] |=> bptr != $past(bptr));

  assert_mode_ones_R3: assert property (@(posedge clk) disable iff (rst)
    acc_r && addr == 4'd11 |-> rdata[1:0] == 2'b11);

  assert_mode_step_R4: assert property (@(posedge clk) disable iff (rst)
    acc_r && addr == 4'd11 |=> mctr == $past(mctr) + 2'd1);

  assert_mask_upper_R6: assert property (@(posedge clk) disable iff (rst)
    acc_r && addr == 4'd15 |-> rdata[7:4] == 4'hF);

  assert_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    hold_ack |=> $stable(cmd_o) && $stable(mask_o) && $stable(bptr));

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
    !sel |-> rdata == 8'h00);
endmodule

bind dma_hostif dma_hostif_chk u_chk (
  .clk(clk), .rst(rst), .sel(sel), .hold_ack(hold_ack), .rd(rd), .wr(wr),
  .addr(addr), .rdata(rdata), .cmd_o(cmd_o), .mask_o(mask_o),
  .bptr(bptr), .mctr(mctr)
);

// File: tb/dma_hostif_tb.sv
module dma_hostif_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, sel = 0, hold_ack = 0, rd = 0, wr = 0, tmp_load = 0;
  logic [3:0] addr = 0, dreq_in = 0, tc_set = 0;
  logic [7:0] wdata = 0, tmp_data = 0, rdata, cmd_o;
  logic [23:0] mode_o;
  logic [3:0] req_o, mask_o;
  logic [63:0] ch_addr_o, ch_cnt_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_hostif u_dut (.clk(clk), .rst(rst), .sel(sel), .hold_ack(hold_ack), .rd(rd), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .dreq_in(dreq_in), .tc_set(tc_set),
    .tmp_load(tmp_load), .tmp_data(tmp_data), .cmd_o(cmd_o), .mode_o(mode_o),
    .req_o(req_o), .mask_o(mask_o), .ch_addr_o(ch_addr_o), .ch_cnt_o(ch_cnt_o));

  always @(negedge clk) begin
    if (rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [7:0] d);
    @(posedge clk) #1;
    addr = a; wdata = d; wr = 1;
    @(posedge clk) #1;
    wr = 0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [7:0] e, string t);
    @(posedge clk) #1;
    addr = a; rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk) #1;
    rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0; sel = 1;
    chk("R2 reset mask", mask_o, 4'hF);
    chk("R2 reset cmd", cmd_o, 8'h00);
    rd_chk(4'd8, 8'h00, "R8 reset status");
    rd_chk(4'd13, 8'h00, "R9 reset temp");

    wr_reg(4'd8, 8'hA5);
    chk("R7 cmd out", cmd_o, 8'hA5);
    rd_chk(4'd10, 8'hA5, "R7 cmd read");

    wr_reg(4'd2, 8'h34);
    wr_reg(4'd2, 8'h12);
    chk("R1 ch1 addr", ch_addr_o[31:16], 16'h1234);
    rd_chk(4'd2, 8'h34, "R1 read low");
    rd_chk(4'd2, 8'h12, "R1 read high");
    wr_reg(4'd3, 8'h78);
    wr_reg(4'd12, 8'h00);
    wr_reg(4'd3, 8'h9A);
    chk("R1 clear pointer count", ch_cnt_o[31:16], 16'h009A);

    wr_reg(4'd11, 8'h5A);
    wr_reg(4'd11, 8'h84);
    chk("R3 mode out ch2", mode_o[17:12], 6'b010110);
    rd_chk(4'd11, 8'h87, "R3 mode ch0");
    rd_chk(4'd11, 8'h03, "R4 mode ch1");
    rd_chk(4'd11, 8'h5B, "R4 mode ch2");
    rd_chk(4'd11, 8'h03, "R4 mode ch3");
    rd_chk(4'd11, 8'h87, "R4 mode wrap");
    rd_chk(4'd11, 8'h03, "R4 mode ch1 again");
    rd_chk(4'd12, 8'hFF, "R4 restart read");
    rd_chk(4'd11, 8'h87, "R4 restart to ch0");

    wr_reg(4'd9, 8'h06);
    chk("R5 req set", req_o, 4'b0100);
    rd_chk(4'd9, 8'hF4, "R5 req read");
    wr_reg(4'd9, 8'h02);
    rd_chk(4'd9, 8'hF0, "R5 req clear");

    wr_reg(4'd14, 8'hFF);
    chk("R6 clear all masks", mask_o, 4'h0);
    wr_reg(4'd10, 8'h07);
    chk("R6 single mask", mask_o, 4'b1000);
    wr_reg(4'd15, 8'h05);
    rd_chk(4'd15, 8'hF5, "R6 mask read");

    dreq_in = 4'b1010;
    @(posedge clk) #1 tc_set = 4'b1010;
    @(posedge clk) #1 tc_set = 4'b0000;
    rd_chk(4'd8, 8'hAA, "R8 status flags");
    rd_chk(4'd8, 8'hA0, "R8 flags cleared on read");
    @(posedge clk) #1;
    addr = 4'd8; rd = 1; tc_set = 4'b0001;
    exp_q.push_back(8'hA0); tag_q.push_back("R8 read during pulse");
    @(posedge clk) #1;
    rd = 0; tc_set = 0;
    rd_chk(4'd8, 8'hA1, "R8 pulse survives read");

    @(posedge clk) #1 tmp_load = 1; tmp_data = 8'h3C;
    @(posedge clk) #1 tmp_load = 0;
    rd_chk(4'd13, 8'h3C, "R9 temp read");

    hold_ack = 1;
    wr_reg(4'd8, 8'hFF);
    chk("R10 hold blocks write", cmd_o, 8'hA5);
    rd_chk(4'd8, 8'h00, "R10 hold blocks read");
    hold_ack = 0; sel = 0;
    wr_reg(4'd14, 8'h00);
    chk("R10 deselected blocks command", mask_o, 4'h5);
    sel = 1;

    dreq_in = 0;
    wr_reg(4'd12, 8'h00);
    wr_reg(4'd0, 8'h11);
    wr_reg(4'd13, 8'h00);
    chk("R2 mclr cmd", cmd_o, 8'h00);
    chk("R2 mclr mask", mask_o, 4'hF);
    chk("R2 mclr req", req_o, 4'h0);
    rd_chk(4'd13, 8'h00, "R2 mclr temp");
    rd_chk(4'd8, 8'h00, "R2 mclr status");
    rd_chk(4'd11, 8'h87, "R2 mclr mode counter");
    wr_reg(4'd0, 8'h22);
    chk("R2 mclr pointer", ch_addr_o[15:0], 16'h0022);

    wr_reg(4'd12, 8'hFF);
    wr_reg(4'd0, 8'h44);
    chk("R11 clear pointer ignores data", ch_addr_o[15:0], 16'h0044);
    chk("R11 mask untouched", mask_o, 4'hF);

    repeat (2) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule